// File: doc/BRIEF.md
# CAN Transmit Buffer Scheduler

This block manages three transmit slots in a CAN controller. Each slot has a small control and status word: a pending-request bit, a two-bit priority, and three sticky outcome flags (cancelled, arbitration lost, frame error). Software marks a slot pending through a control write. An enabled active-low request pin can also mark it pending. Whenever the bus is idle and no frame is in flight, the block picks one pending slot and hands its index to the protocol engine.

The engine reports one result per frame: done, error or arbitration lost. The block turns these into slot status and interrupt flags. A single slot is withdrawn by writing its request bit to zero. A sticky cancel-all control bit withdraws every pending slot and holds off new frames until software clears it. The slot that is on the wire at any moment cannot be changed.

Top module: `can_tx_sched`

## Requirements
- R1: After reset, all request, priority, outcome flag, pin-enable, cancel-all and interrupt bits are 0, and `pin_level_o` reads 3'b111.
- R2: A pulse on `ctl_wr[i]` loads slot i with `ctl_wdata`, where bit 2 is the request and bits 1:0 are the priority. If bit 2 is 1, the request is set and slot i's cancelled, lost and error flags clear, all on the same clock edge.
- R3: When `bus_idle` is high, no frame is in flight, cancel-all is clear and at least one request is set, `eng_start` pulses one cycle later with `eng_idx` naming the pending slot of highest priority (3 highest, 0 lowest). On equal priority the larger slot index is chosen. Priority is evaluated again before every start.
- R4: `tx_busy` rises together with `eng_start` and stays high until the edge after a `eng_done`, `eng_err` or `eng_lost` pulse. No new start occurs while it is high.
- R5: On `eng_done`, the in-flight slot's request clears and its transmit interrupt flag (`iflag_o[i]`) sets.
- R6: On `eng_err`, the in-flight slot's request stays set, its error flag sets, and the message-error interrupt flag `iflag_o[3]` sets. On `eng_lost`, the request stays set and its lost flag sets.
- R7: Writing request 0 to a pending slot that is not in flight clears the request and leaves its cancelled flag at 0.
- R8: A control write to the in-flight slot is ignored: neither its request nor its priority changes. This includes the slot chosen in the cycle a start is decided.
- R9: While cancel-all (`abort_all_o`) is 1, every set request of a slot not in flight is cleared on the next edge and that slot's cancelled flag sets. No `eng_start` occurs.
- R10: Each `rts_n` pin passes through two synchronizer flops, visible as `pin_level_o`. A falling edge on an enabled pin sets that slot's request (as in R2) on the third clock edge after the low level is first sampled. A disabled pin does not affect the requests.
- R11: `pin_cfg_wr` updates `pin_en_o` only while `cfg_mode` is high.
- R12: `iflag_o` bits 2:0 are the per-slot transmit-done flags and bit 3 is the message-error flag. Writing 1 to a bit of `iflag_clr` clears that flag; if a flag is set in the same cycle, the set wins. `irq` is high whenever some flag is set and its bit in the enable register (loaded by `ien_wr`) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Configuration mode; gates pin-mode writes |
| ctl_wr | input | 3 | Per-slot control write strobe |
| ctl_wdata | input | 3 | {request, priority[1:0]} |
| pin_cfg_wr | input | 1 | Pin-mode write strobe |
| pin_cfg_wdata | input | 3 | Per-pin request-input enable |
| abort_all_wr | input | 1 | Cancel-all write strobe |
| abort_all_wdata | input | 1 | New cancel-all value |
| ien_wr | input | 1 | Interrupt-enable write strobe |
| ien_wdata | input | 4 | Interrupt enables, same layout as iflag_o |
| iflag_clr | input | 4 | Write-1-to-clear for interrupt flags |
| rts_n | input | 3 | Active-low request pins |
| bus_idle | input | 1 | Bus free for a new frame |
| eng_done | input | 1 | Engine: frame sent |
| eng_err | input | 1 | Engine: frame error |
| eng_lost | input | 1 | Engine: arbitration lost |
| eng_start | output | 1 | Start strobe to the engine |
| eng_idx | output | 2 | Slot chosen for the frame |
| tx_busy | output | 1 | Frame in flight |
| req_o | output | 3 | Request bits |
| prio_o | output | 6 | Priorities, slot i at [2i+1:2i] |
| abt_o | output | 3 | Cancelled flags |
| lost_o | output | 3 | Arbitration-lost flags |
| err_o | output | 3 | Frame-error flags |
| pin_en_o | output | 3 | Pin request-input enables |
| pin_level_o | output | 3 | Synchronized pin levels |
| abort_all_o | output | 1 | Cancel-all bit |
| iflag_o | output | 4 | Interrupt flags |
| irq | output | 1 | Interrupt output |

## Verification
A wrong slot choice shows on `eng_idx` in the very cycle `eng_start` pulses. A request bit that is lost or left stale shows on `req_o` one edge after the write, pin edge or engine result that caused it. Errors in the in-flight lock or the cancel-all sweep show as a request that drops or survives one cycle too early or too late. A reference model steps along with the design and compares every output on every clock, so any of these shows within one cycle of the divergence.

// File: rtl/can_tx_sched.sv
module can_tx_sched #(
  parameter int N_BUF  = 3,
  parameter int PRIO_W = 2,
  localparam int IDX_W = (N_BUF > 1) ? $clog2(N_BUF) : 1,
  localparam int IF_W  = N_BUF + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_mode,
  input  logic [N_BUF-1:0]        ctl_wr,
  input  logic [PRIO_W:0]         ctl_wdata,
  input  logic                    pin_cfg_wr,
  input  logic [N_BUF-1:0]        pin_cfg_wdata,
  input  logic                    abort_all_wr,
  input  logic                    abort_all_wdata,
  input  logic                    ien_wr,
  input  logic [IF_W-1:0]         ien_wdata,
  input  logic [IF_W-1:0]         iflag_clr,
  input  logic [N_BUF-1:0]        rts_n,
  input  logic                    bus_idle,
  input  logic                    eng_done,
  input  logic                    eng_err,
  input  logic                    eng_lost,
  output logic                    eng_start,
  output logic [IDX_W-1:0]        eng_idx,
  output logic                    tx_busy,
  output logic [N_BUF-1:0]        req_o,
  output logic [N_BUF*PRIO_W-1:0] prio_o,
  output logic [N_BUF-1:0]        abt_o,
  output logic [N_BUF-1:0]        lost_o,
  output logic [N_BUF-1:0]        err_o,
  output logic [N_BUF-1:0]        pin_en_o,
  output logic [N_BUF-1:0]        pin_level_o,
  output logic                    abort_all_o,
  output logic [IF_W-1:0]         iflag_o,
  output logic                    irq
);

  logic [N_BUF-1:0]  req_q, abt_q, lost_q, err_q, pen_q;
  logic [N_BUF-1:0]  s1_q, s2_q, s3_q, fall;
  logic [PRIO_W-1:0] prio_q [N_BUF];
  logic [IF_W-1:0]   ifl_q, ien_q;
  logic              aall_q, busy_q, start_q;
  logic [IDX_W-1:0]  cur_q, sel;
  logic [PRIO_W-1:0] best;
  logic              sel_vld, start_now, result;
  logic [N_BUF-1:0]  lock, hit, set_req, clr_req, wr_ok;

  always_comb begin
    sel = '0;
    best = '0;
    sel_vld = 1'b0;
    for (int i = 0; i < N_BUF; i++) begin
      if (req_q[i] && (!sel_vld || prio_q[i] >= best)) begin
        sel = IDX_W'(i);
        best = prio_q[i];
        sel_vld = 1'b1;
      end
    end
  end

  assign start_now = sel_vld && bus_idle && !busy_q && !aall_q;
  assign result    = busy_q && (eng_done || eng_err || eng_lost);
  assign fall      = s3_q & ~s2_q;

  always_comb begin
    for (int i = 0; i < N_BUF; i++) begin
      hit[i]     = busy_q && (cur_q == IDX_W'(i));
      lock[i]    = hit[i] || (!busy_q && start_now && (sel == IDX_W'(i)));
      wr_ok[i]   = ctl_wr[i] && !lock[i];
      set_req[i] = !lock[i] && ((ctl_wr[i] && ctl_wdata[PRIO_W]) || (fall[i] && pen_q[i]));
      clr_req[i] = wr_ok[i] && !ctl_wdata[PRIO_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '1;
      s2_q <= '1;
      s3_q <= '1;
    end else begin
      s1_q <= rts_n;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  generate
    for (genvar g = 0; g < N_BUF; g++) begin : g_slot
      logic r_n, a_n;
      always_comb begin
        r_n = req_q[g];
        a_n = abt_q[g];
        if (hit[g] && eng_done) r_n = 1'b0;
        if (clr_req[g]) r_n = 1'b0;
        if (set_req[g]) begin
          r_n = 1'b1;
          a_n = 1'b0;
        end
        if (aall_q && r_n && !lock[g]) begin
          r_n = 1'b0;
          a_n = 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          req_q[g]  <= 1'b0;
          abt_q[g]  <= 1'b0;
          lost_q[g] <= 1'b0;
          err_q[g]  <= 1'b0;
          prio_q[g] <= '0;
        end else begin
          req_q[g] <= r_n;
          abt_q[g] <= a_n;
          if (wr_ok[g]) prio_q[g] <= ctl_wdata[PRIO_W-1:0];
          if (set_req[g]) begin
            lost_q[g] <= 1'b0;
            err_q[g]  <= 1'b0;
          end else begin
            if (hit[g] && eng_lost) lost_q[g] <= 1'b1;
            if (hit[g] && eng_err)  err_q[g]  <= 1'b1;
          end
        end
      end

      assign prio_o[g*PRIO_W +: PRIO_W] = prio_q[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cur_q   <= '0;
      start_q <= 1'b0;
      aall_q  <= 1'b0;
      pen_q   <= '0;
      ien_q   <= '0;
      ifl_q   <= '0;
    end else begin
      start_q <= start_now;
      if (start_now) begin
        busy_q <= 1'b1;
        cur_q  <= sel;
      end else if (result) begin
        busy_q <= 1'b0;
      end
      if (abort_all_wr) aall_q <= abort_all_wdata;
      if (pin_cfg_wr && cfg_mode) pen_q <= pin_cfg_wdata;
      if (ien_wr) ien_q <= ien_wdata;
      ifl_q <= (ifl_q & ~iflag_clr) | {busy_q && eng_err, hit & {N_BUF{eng_done}}};
    end
  end

  assign eng_start   = start_q;
  assign eng_idx     = cur_q;
  assign tx_busy     = busy_q;
  assign req_o       = req_q;
  assign abt_o       = abt_q;
  assign lost_o      = lost_q;
  assign err_o       = err_q;
  assign pin_en_o    = pen_q;
  assign pin_level_o = s2_q;
  assign abort_all_o = aall_q;
  assign iflag_o     = ifl_q;
  assign irq         = |(ifl_q & ien_q);

  p_start_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (tx_busy && req_o[eng_idx]));

  p_hold_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !(eng_done || eng_err || eng_lost)) |=> (tx_busy && !eng_start));

  p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && eng_done) |=> (!req_o[$past(eng_idx)] && iflag_o[$past(eng_idx)]));

  p_err_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && eng_err) |=> (req_o[$past(eng_idx)] && err_o[$past(eng_idx)] && iflag_o[N_BUF]));

  p_lost_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && eng_lost) |=> (req_o[$past(eng_idx)] && lost_o[$past(eng_idx)]));

  p_locked_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !result) |=> (prio_q[cur_q] == $past(prio_q[cur_q])));

  p_no_start_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_all_o |=> !eng_start);

  p_pin_cfg_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(pin_en_o));

endmodule

// File: tb/tb_can_tx_sched.sv
module tb_can_tx_sched;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_mode = 1'b0;
  logic [2:0] ctl_wr = '0;
  logic [2:0] ctl_wdata = '0;
  logic pin_cfg_wr = 1'b0;
  logic [2:0] pin_cfg_wdata = '0;
  logic abort_all_wr = 1'b0, abort_all_wdata = 1'b0;
  logic ien_wr = 1'b0;
  logic [3:0] ien_wdata = '0, iflag_clr = '0;
  logic [2:0] rts_n = '1;
  logic bus_idle = 1'b0, eng_done = 1'b0, eng_err = 1'b0, eng_lost = 1'b0;
  logic eng_start, tx_busy, abort_all_o, irq;
  logic [1:0] eng_idx;
  logic [2:0] req_o, abt_o, lost_o, err_o, pin_en_o, pin_level_o;
  logic [5:0] prio_o;
  logic [3:0] iflag_o;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  can_tx_sched dut (.*);

  always #4 clk = ~clk;

  int mreq[3], mpr[3], mab[3], mlo[3], mer[3], mpe[3], ms1[3], ms2[3], ms3[3];
  int mif[4], mie[4];
  int maa, mbusy, mcur, mst, msel, mbest, mgo, lk, fl, wr, st, r, a;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        mreq[i] = 0; mpr[i] = 0; mab[i] = 0; mlo[i] = 0; mer[i] = 0; mpe[i] = 0;
        ms1[i] = 1; ms2[i] = 1; ms3[i] = 1;
      end
      for (int k = 0; k < 4; k++) begin mif[k] = 0; mie[k] = 0; end
      maa = 0; mbusy = 0; mcur = 0; mst = 0;
    end else begin
      msel = -1; mbest = -1;
      for (int i = 0; i < 3; i++)
        if (mreq[i] != 0 && mpr[i] >= mbest) begin msel = i; mbest = mpr[i]; end
      mgo = (msel >= 0 && bus_idle && mbusy == 0 && maa == 0) ? 1 : 0;
      for (int k = 0; k < 4; k++) if (iflag_clr[k]) mif[k] = 0;
      for (int i = 0; i < 3; i++) begin
        lk = (mbusy != 0) ? (mcur == i) : (mgo != 0 && msel == i);
        fl = (ms3[i] == 1 && ms2[i] == 0) ? 1 : 0;
        wr = (ctl_wr[i] && lk == 0) ? 1 : 0;
        st = (lk == 0 && ((wr != 0 && ctl_wdata[2]) || (fl != 0 && mpe[i] != 0))) ? 1 : 0;
        r = mreq[i]; a = mab[i];
        if (mbusy != 0 && mcur == i && eng_done) begin r = 0; mif[i] = 1; end
        if (wr != 0 && !ctl_wdata[2]) r = 0;
        if (wr != 0) mpr[i] = int'(ctl_wdata[1:0]);
        if (st != 0) begin r = 1; a = 0; mlo[i] = 0; mer[i] = 0; end
        if (maa != 0 && r != 0 && lk == 0) begin r = 0; a = 1; end
        if (mbusy != 0 && mcur == i && eng_lost) mlo[i] = 1;
        if (mbusy != 0 && mcur == i && eng_err) mer[i] = 1;
        mreq[i] = r; mab[i] = a;
      end
      if (mbusy != 0 && eng_err) mif[3] = 1;
      if (mgo != 0) begin mbusy = 1; mcur = msel; end
      else if (mbusy != 0 && (eng_done || eng_err || eng_lost)) mbusy = 0;
      mst = mgo;
      if (abort_all_wr) maa = abort_all_wdata;
      if (pin_cfg_wr && cfg_mode) for (int i = 0; i < 3; i++) mpe[i] = pin_cfg_wdata[i];
      if (ien_wr) for (int k = 0; k < 4; k++) mie[k] = ien_wdata[k];
      for (int i = 0; i < 3; i++) begin ms3[i] = ms2[i]; ms2[i] = ms1[i]; ms1[i] = rts_n[i]; end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int vec3(input int v[3]);
    return (v[0] != 0 ? 1 : 0) | (v[1] != 0 ? 2 : 0) | (v[2] != 0 ? 4 : 0);
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int pv, fv, iq;
      pv = mpr[0] | (mpr[1] << 2) | (mpr[2] << 4);
      fv = 0; iq = 0;
      for (int k = 0; k < 4; k++) begin
        if (mif[k] != 0) fv |= (1 << k);
        if (mif[k] != 0 && mie[k] != 0) iq = 1;
      end
      chk("R3", "eng_start", int'(eng_start), mst);
      if (mst != 0) chk("R3", "eng_idx", int'(eng_idx), mcur);
      chk("R4", "tx_busy", int'(tx_busy), mbusy);
      chk("R2", "req_o", int'(req_o), vec3(mreq));
      chk("R2", "prio_o", int'(prio_o), pv);
      chk("R9", "abt_o", int'(abt_o), vec3(mab));
      chk("R6", "lost_o", int'(lost_o), vec3(mlo));
      chk("R6", "err_o", int'(err_o), vec3(mer));
      chk("R11", "pin_en_o", int'(pin_en_o), vec3(mpe));
      chk("R10", "pin_level_o", int'(pin_level_o), vec3(ms2));
      chk("R9", "abort_all_o", int'(abort_all_o), maa);
      chk("R12", "iflag_o", int'(iflag_o), fv);
      chk("R12", "irq", int'(irq), iq);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic ctl(input int slot, input bit rq, input int pr);
    ctl_wr = 3'(1 << slot); ctl_wdata = {rq, 2'(pr)};
    @(negedge clk); ctl_wr = '0;
  endtask

  task automatic wait_start(input string tag, input int exp_idx);
    int n = 0;
    while (!eng_start && n < 50) begin @(negedge clk); n++; end
    chk(tag, "start seen", int'(eng_start), 1);
    chk(tag, "chosen slot", int'(eng_idx), exp_idx);
    bus_idle = 1'b0;
  endtask

  task automatic result(input int kind);
    eng_done = (kind == 0); eng_err = (kind == 1); eng_lost = (kind == 2);
    @(negedge clk);
    eng_done = 0; eng_err = 0; eng_lost = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req after reset", int'(req_o), 0);
    chk("R1", "pins after reset", int'(pin_level_o), 7);
    chk("R1", "irq after reset", int'(irq), 0);

    ien_wr = 1; ien_wdata = 4'hF; @(negedge clk); ien_wr = 0;
    ctl(0, 1, 3); ctl(1, 1, 1); ctl(2, 1, 3);
    chk("R2", "three pending", int'(req_o), 7);
    bus_idle = 1;
    wait_start("R3", 2);
    chk("R4", "busy with start", int'(tx_busy), 1);
    ctl(2, 0, 0);
    chk("R8", "locked req kept", int'(req_o[2]), 1);
    chk("R8", "locked prio kept", int'(prio_o[5:4]), 3);
    result(0);
    chk("R5", "done clears req", int'(req_o), 3);
    chk("R5", "done flag", int'(iflag_o), 4);
    chk("R12", "irq on done", int'(irq), 1);
    chk("R4", "idle after done", int'(tx_busy), 0);

    bus_idle = 1;
    wait_start("R3", 0);
    result(2);
    chk("R6", "lost keeps req", int'(req_o[0]), 1);
    chk("R6", "lost flag", int'(lost_o[0]), 1);
    bus_idle = 1;
    wait_start("R3", 0);
    result(1);
    chk("R6", "err flag", int'(err_o[0]), 1);
    chk("R6", "merr flag", int'(iflag_o[3]), 1);

    ien_wr = 1; ien_wdata = 4'h0; @(negedge clk); ien_wr = 0;
    chk("R12", "irq masked", int'(irq), 0);
    iflag_clr = 4'hF; @(negedge clk); iflag_clr = 0;
    chk("R12", "flags cleared", int'(iflag_o), 0);
    ien_wr = 1; ien_wdata = 4'hF; @(negedge clk); ien_wr = 0;

    ctl(0, 1, 3);
    chk("R2", "rewrite clears lost", int'(lost_o[0]), 0);
    chk("R2", "rewrite clears err", int'(err_o[0]), 0);
    ctl(1, 0, 1);
    chk("R7", "single abort req", int'(req_o[1]), 0);
    chk("R7", "single abort no flag", int'(abt_o[1]), 0);

    ctl(1, 1, 2);
    abort_all_wr = 1; abort_all_wdata = 1; @(negedge clk); abort_all_wr = 0;
    bus_idle = 1;
    @(negedge clk);
    chk("R9", "all cancelled", int'(req_o), 0);
    chk("R9", "cancel flags", int'(abt_o), 3);
    ctl(2, 1, 1);
    @(negedge clk);
    chk("R9", "late req cancelled", int'(req_o[2]), 0);
    repeat (4) @(negedge clk);
    abort_all_wr = 1; abort_all_wdata = 0; @(negedge clk); abort_all_wr = 0;
    ctl(1, 1, 2); ctl(2, 1, 1);
    wait_start("R3", 1);
    ctl(0, 1, 3);
    abort_all_wr = 1; abort_all_wdata = 1; @(negedge clk); abort_all_wr = 0;
    @(negedge clk);
    chk("R9", "in-flight survives", int'(req_o[1]), 1);
    chk("R9", "others cancelled", int'(req_o[0]) + int'(req_o[2]), 0);
    result(0);
    abort_all_wr = 1; abort_all_wdata = 0; @(negedge clk); abort_all_wr = 0;

    pin_cfg_wr = 1; pin_cfg_wdata = 3'b111; @(negedge clk); pin_cfg_wr = 0;
    chk("R11", "cfg ignored outside mode", int'(pin_en_o), 0);
    cfg_mode = 1;
    pin_cfg_wr = 1; pin_cfg_wdata = 3'b001; @(negedge clk); pin_cfg_wr = 0;
    cfg_mode = 0;
    chk("R11", "cfg written", int'(pin_en_o), 1);
    rts_n = 3'b100;
    @(negedge clk); @(negedge clk);
    chk("R10", "level synced", int'(pin_level_o), 4);
    chk("R10", "not yet set", int'(req_o), 0);
    @(negedge clk);
    chk("R10", "enabled pin sets", int'(req_o), 1);
    chk("R10", "disabled pin no effect", int'(req_o[1]), 0);
    rts_n = 3'b111;
    bus_idle = 1;
    wait_start("R3", 0);
    result(0);
    repeat (4) @(negedge clk);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule